// File: doc/BRIEF.md
# Clock Mode Switch Sequencer

This block is a hardware state machine that moves the system onto a new clock mode without losing the contents of external SDRAM. A host raises a request together with a 4-bit target mode. The sequencer then runs a fixed series of steps, and each step waits for the step before it to finish:

1. It forces interrupts off.
2. It asks every bus master to stop and waits for an acknowledge.
3. It issues a dummy SDRAM read.
4. It asks the SDRAM controller for self-refresh and waits until the controller reports it.
5. It writes the target mode word and then the clock-control word with the switch enable set.
6. It lets the clocks settle for a fixed number of cycles.
7. It leaves self-refresh and waits for the status to clear.
8. It finishes by releasing the interrupt override and the bus stop request.

The sequencer does not read the clock-control register itself. It samples that register's current contents on an input port and writes them back with only the enable bit added, so every other field keeps its value. The host sees a busy level for the whole sequence and a one-cycle done pulse at its end.

Top module: `clkmode_switch_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, done, irq_mask, quiesce_req, dummy_rd, sr_req, swmode_wr and ctl_wr are all 0.
- R2: If req_valid is high on a clock edge while busy is low, the request is accepted. From the next cycle busy and irq_mask are 1, and req_mode is latched at that edge.
- R3: quiesce_req rises only while irq_mask is already high. dummy_rd and sr_req stay 0 until quiesce_ack has been sampled at 1.
- R4: dummy_rd is a one-cycle pulse, and sr_req rises in the cycle right after it.
- R5: While sr_stat is sampled at 0, sr_req stays at 1 and no mode write happens. The mode write comes in the cycle after sr_stat is first sampled at 1.
- R6: swmode_wr is a one-cycle pulse. swmode_wdata carries the latched mode in bits 27:24 and 0 in every other bit. ctl_wr follows in the next cycle.
- R7: ctl_wr is a one-cycle pulse. ctl_wdata is ctl_rd_data as sampled during the swmode_wr cycle, with bit 31 forced to 1 and all other bits unchanged.
- R8: After the ctl_wr cycle, sr_req stays at 1 for exactly SETTLE_CYC cycles and then drops to 0.
- R9: After sr_req drops, done stays 0 and irq_mask stays 1 until sr_stat has been sampled at 0.
- R10: done is a one-cycle pulse. In the done cycle busy is 1 while irq_mask and quiesce_req are 0. In the next cycle busy is 0.
- R11: A request that arrives while busy is 1 is ignored. The sequence does not restart, and the latched mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request to switch clock mode |
| req_mode | input | 4 | Target clock mode, taken when a request is accepted |
| busy | output | 1 | High from the cycle after acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| irq_mask | output | 1 | High forces interrupts off |
| quiesce_req | output | 1 | Asks all bus masters to stop |
| quiesce_ack | input | 1 | All bus masters are idle |
| dummy_rd | output | 1 | One-cycle dummy SDRAM read strobe |
| sr_req | output | 1 | Refresh-control bit 0: ask SDRAM for self-refresh |
| sr_stat | input | 1 | Status bit 0: SDRAM is in self-refresh |
| swmode_wr | output | 1 | Write strobe for the switch-mode register |
| swmode_wdata | output | 32 | Switch-mode word, target mode in bits 27:24 |
| ctl_rd_data | input | 32 | Current contents of the clock-control register |
| ctl_wr | output | 1 | Write strobe for the clock-control register |
| ctl_wdata | output | 32 | Clock-control word with enable bit 31 set |

## Verification
The bench builds the sequencer with its default SETTLE_CYC of 256. This means the settle window is measured at its real length, including the 8-bit counter's terminal value of 255. Each run changes how long quiesce_ack and sr_stat are held back. One run holds them back for zero cycles, which exercises the shortest path through every wait state. The clock-control input values used in the runs have bit 31 both clear and already set, so the bench can check that only the enable bit changes.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    localparam int MODE_W     = 4;
    localparam int REG_W      = 32;
    localparam int SWM_LSB    = 24;
    localparam int CTL_EN_BIT = 31;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MASK,
        ST_QUIESCE,
        ST_DUMMY,
        ST_SR_ON,
        ST_MODE_WR,
        ST_EN_WR,
        ST_SETTLE,
        ST_SR_OFF,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic irq_mask;
        logic quiesce_req;
        logic dummy_rd;
        logic sr_req;
        logic swm_wr;
        logic ctl_wr;
        logic accept;
        logic tmr_clear;
    } seq_ctrl_t;

    function automatic logic [REG_W-1:0] fmt_swmode(input logic [MODE_W-1:0] mode);
        logic [REG_W-1:0] w;
        w = '0;
        w[SWM_LSB +: MODE_W] = mode;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] set_enable(input logic [REG_W-1:0] cur);
        logic [REG_W-1:0] w;
        w = cur;
        w[CTL_EN_BIT] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/clkmode_settle_timer.sv
module clkmode_settle_timer #(
    parameter int SETTLE_CYC = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (run && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LAST);

endmodule

// File: rtl/clkmode_seq_fsm.sv
module clkmode_seq_fsm
    import clkmode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  logic      quiesce_ack,
    input  logic      sr_stat,
    input  logic      settle_done,
    output seq_ctrl_t ctrl
);
    seq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid)   state_nx = ST_MASK;
            ST_MASK:                     state_nx = ST_QUIESCE;
            ST_QUIESCE: if (quiesce_ack) state_nx = ST_DUMMY;
            ST_DUMMY:                    state_nx = ST_SR_ON;
            ST_SR_ON:   if (sr_stat)     state_nx = ST_MODE_WR;
            ST_MODE_WR:                  state_nx = ST_EN_WR;
            ST_EN_WR:                    state_nx = ST_SETTLE;
            ST_SETTLE:  if (settle_done) state_nx = ST_SR_OFF;
            ST_SR_OFF:  if (!sr_stat)    state_nx = ST_FIN;
            ST_FIN:                      state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ctrl             = '0;
        ctrl.busy        = (state != ST_IDLE);
        ctrl.accept      = (state == ST_IDLE) && req_valid;
        ctrl.done        = (state == ST_FIN);
        ctrl.irq_mask    = (state != ST_IDLE) && (state != ST_FIN);
        ctrl.quiesce_req = ctrl.irq_mask && (state != ST_MASK);
        ctrl.dummy_rd    = (state == ST_DUMMY);
        ctrl.sr_req      = (state == ST_SR_ON) || (state == ST_MODE_WR) ||
                           (state == ST_EN_WR) || (state == ST_SETTLE);
        ctrl.swm_wr      = (state == ST_MODE_WR);
        ctrl.ctl_wr      = (state == ST_EN_WR);
        ctrl.tmr_clear   = (state != ST_SETTLE);
    end

endmodule

// File: rtl/clkmode_seq_regs.sv
module clkmode_seq_regs
    import clkmode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              capture,
    input  logic [REG_W-1:0]  ctl_rd_data,
    output logic [REG_W-1:0]  swmode_word,
    output logic [REG_W-1:0]  ctl_word
);
    logic [MODE_W-1:0] mode_q;
    logic [REG_W-1:0]  ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            ctl_q  <= '0;
        end else begin
            if (accept)  mode_q <= req_mode;
            if (capture) ctl_q  <= set_enable(ctl_rd_data);
        end
    end

    assign swmode_word = fmt_swmode(mode_q);
    assign ctl_word    = ctl_q;

endmodule

// File: rtl/clkmode_switch_seq.sv
module clkmode_switch_seq
    import clkmode_pkg::*;
#(
    parameter int SETTLE_CYC = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    output logic              busy,
    output logic              done,
    output logic              irq_mask,
    output logic              quiesce_req,
    input  logic              quiesce_ack,
    output logic              dummy_rd,
    output logic              sr_req,
    input  logic              sr_stat,
    output logic              swmode_wr,
    output logic [REG_W-1:0]  swmode_wdata,
    input  logic [REG_W-1:0]  ctl_rd_data,
    output logic              ctl_wr,
    output logic [REG_W-1:0]  ctl_wdata
);
    seq_ctrl_t ctrl;
    logic      settle_done;

    clkmode_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .quiesce_ack (quiesce_ack),
        .sr_stat     (sr_stat),
        .settle_done (settle_done),
        .ctrl        (ctrl)
    );

    clkmode_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (ctrl.tmr_clear),
        .run     (!ctrl.tmr_clear),
        .expired (settle_done)
    );

    clkmode_seq_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .accept      (ctrl.accept),
        .req_mode    (req_mode),
        .capture     (ctrl.swm_wr),
        .ctl_rd_data (ctl_rd_data),
        .swmode_word (swmode_wdata),
        .ctl_word    (ctl_wdata)
    );

    assign busy        = ctrl.busy;
    assign done        = ctrl.done;
    assign irq_mask    = ctrl.irq_mask;
    assign quiesce_req = ctrl.quiesce_req;
    assign dummy_rd    = ctrl.dummy_rd;
    assign sr_req      = ctrl.sr_req;
    assign swmode_wr   = ctrl.swm_wr;
    assign ctl_wr      = ctrl.ctl_wr;

endmodule

// File: rtl/clkmode_switch_seq_chk.sv
module clkmode_switch_seq_chk
    import clkmode_pkg::*;
#(
    parameter int SETTLE_CYC = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [MODE_W-1:0] req_mode,
    input logic              busy,
    input logic              done,
    input logic              irq_mask,
    input logic              quiesce_req,
    input logic              quiesce_ack,
    input logic              dummy_rd,
    input logic              sr_req,
    input logic              sr_stat,
    input logic              swmode_wr,
    input logic [REG_W-1:0]  swmode_wdata,
    input logic [REG_W-1:0]  ctl_rd_data,
    input logic              ctl_wr,
    input logic [REG_W-1:0]  ctl_wdata
);
    logic        counting;
    logic [31:0] win_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            counting <= 1'b0;
            win_cnt  <= '0;
        end else if (ctl_wr) begin
            counting <= 1'b1;
            win_cnt  <= '0;
        end else if (counting) begin
            if (sr_req) win_cnt <= win_cnt + 1;
            else        counting <= 1'b0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && !sr_req && !irq_mask && !ctl_wr)); // R1
    AST_ACCEPT_MASK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (busy && irq_mask)); // R2
    AST_MASK_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(quiesce_req) |-> irq_mask); // R3
    AST_ACK_BEFORE_DUMMY: assert property (@(posedge clk) disable iff (rst)
        $rose(dummy_rd) |-> $past(quiesce_ack)); // R3
    AST_DUMMY_THEN_SR: assert property (@(posedge clk) disable iff (rst)
        dummy_rd |=> (sr_req && !dummy_rd)); // R4
    AST_SR_BEFORE_SWITCH: assert property (@(posedge clk) disable iff (rst)
        $rose(swmode_wr) |-> (sr_req && $past(sr_stat))); // R5
    AST_SWITCH_ORDER: assert property (@(posedge clk) disable iff (rst)
        swmode_wr |=> (ctl_wr && !swmode_wr)); // R6
    AST_ENABLE_BIT: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |-> ctl_wdata[CTL_EN_BIT]); // R7
    AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (rst)
        (counting && !sr_req) |-> (win_cnt == SETTLE_CYC)); // R8
    AST_EXIT_CONFIRMED: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!sr_req && $past(!sr_stat))); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R10

endmodule

bind clkmode_switch_seq clkmode_switch_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (.*);

// File: tb/clkmode_switch_seq_test.sv
module clkmode_switch_seq_test;
    localparam int SETTLE = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_mode = '0;
    logic        busy, done, irq_mask, quiesce_req, dummy_rd, sr_req;
    logic        quiesce_ack = 1'b0;
    logic        sr_stat = 1'b0;
    logic        swmode_wr, ctl_wr;
    logic [31:0] swmode_wdata, ctl_wdata;
    logic [31:0] ctl_rd_data = '0;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] val;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    clkmode_switch_seq #(.SETTLE_CYC(SETTLE)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .busy(busy), .done(done), .irq_mask(irq_mask), .quiesce_req(quiesce_req),
        .quiesce_ack(quiesce_ack), .dummy_rd(dummy_rd), .sr_req(sr_req),
        .sr_stat(sr_stat), .swmode_wr(swmode_wr), .swmode_wdata(swmode_wdata),
        .ctl_rd_data(ctl_rd_data), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, expv, $time);
        end
    endtask

    // monitor: pops expected items as results appear
    bit          in_win = 1'b0;
    int          win_cnt = 0;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (in_win) begin
                if (sr_req) win_cnt++;
                else begin
                    in_win = 1'b0;
                    if (exp_q.size() > 0 && exp_q[0].kind == 2) begin
                        chk(win_cnt == exp_q[0].val, "R8 settle length", win_cnt, exp_q[0].val);
                        void'(exp_q.pop_front());
                    end else chk(1'b0, "R8 unexpected settle end", win_cnt, 0);
                end
            end
            if (swmode_wr) begin
                if (exp_q.size() > 0 && exp_q[0].kind == 0) begin
                    chk(swmode_wdata == exp_q[0].val, "R6 swmode word (R11 latch)",
                        swmode_wdata, exp_q[0].val);
                    void'(exp_q.pop_front());
                end else chk(1'b0, "R6 unexpected swmode write", swmode_wdata, 0);
            end
            if (ctl_wr) begin
                if (exp_q.size() > 0 && exp_q[0].kind == 1) begin
                    chk(ctl_wdata == exp_q[0].val, "R7 control word", ctl_wdata, exp_q[0].val);
                    void'(exp_q.pop_front());
                end else chk(1'b0, "R7 unexpected control write", ctl_wdata, 0);
                in_win  = 1'b1;
                win_cnt = 0;
            end
            if (done) begin
                if (exp_q.size() > 0 && exp_q[0].kind == 3) void'(exp_q.pop_front());
                else chk(1'b0, "R10 unexpected done", 1, 0);
            end
        end
    end

    task automatic run_seq(input logic [3:0] mode, input logic [31:0] ctlv,
                           input int qdly, input int ondly, input int offdly,
                           input bit late_req);
        logic [31:0] ctl_exp;
        ctl_exp = ctlv;
        ctl_exp[31] = 1'b1;
        exp_q.push_back('{0, {4'h0, mode, 24'h0}});
        exp_q.push_back('{1, ctl_exp});
        exp_q.push_back('{2, SETTLE});
        exp_q.push_back('{3, 0});
        ctl_rd_data = ctlv;

        req_valid = 1'b1; req_mode = mode;
        @(negedge clk);
        req_valid = 1'b0; req_mode = ~mode;
        chk(busy && irq_mask && !quiesce_req, "R2 accept", {busy, irq_mask, quiesce_req}, 3'b110);
        @(negedge clk);
        chk(quiesce_req && irq_mask, "R3 quiesce after mask", quiesce_req, 1);
        for (int i = 0; i < qdly; i++) begin
            chk(!dummy_rd && !sr_req, "R3 wait for ack", {dummy_rd, sr_req}, 0);
            if (late_req && i == 0) begin
                req_valid = 1'b1; req_mode = ~mode;
            end
            @(negedge clk);
            if (late_req && i == 0) begin
                req_valid = 1'b0;
                chk(irq_mask && quiesce_req && busy, "R11 no restart",
                    {irq_mask, quiesce_req, busy}, 3'b111);
            end
        end
        quiesce_ack = 1'b1;
        @(negedge clk);
        quiesce_ack = 1'b0;
        chk(dummy_rd && !sr_req, "R4 dummy read", {dummy_rd, sr_req}, 2'b10);
        @(negedge clk);
        chk(sr_req && !dummy_rd, "R4 self-refresh follows", {sr_req, dummy_rd}, 2'b10);
        for (int i = 0; i < ondly; i++) begin
            chk(sr_req && !swmode_wr && !ctl_wr, "R5 wait for entry", {sr_req, swmode_wr}, 2'b10);
            @(negedge clk);
        end
        sr_stat = 1'b1;
        @(negedge clk);
        chk(swmode_wr && sr_req, "R5 mode write after entry", {swmode_wr, sr_req}, 2'b11);
        @(negedge clk);
        chk(ctl_wr && !swmode_wr, "R6 enable follows mode", {ctl_wr, swmode_wr}, 2'b10);
        for (int i = 0; i < SETTLE + 8 && sr_req; i++) @(negedge clk);
        for (int i = 0; i < offdly; i++) begin
            chk(!done && irq_mask && !sr_req, "R9 wait for exit", {done, irq_mask}, 2'b01);
            @(negedge clk);
        end
        sr_stat = 1'b0;
        @(negedge clk);
        chk(done && busy && !irq_mask && !quiesce_req, "R10 done cycle",
            {done, busy, irq_mask, quiesce_req}, 4'b1100);
        @(negedge clk);
        chk(!done && !busy, "R10 after done", {done, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !irq_mask && !quiesce_req, "R1 reset outputs",
            {busy, done, irq_mask, quiesce_req}, 0);
        chk(!dummy_rd && !sr_req && !swmode_wr && !ctl_wr, "R1 reset strobes",
            {dummy_rd, sr_req, swmode_wr, ctl_wr}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !sr_req && !irq_mask, "R1 first cycle", {busy, sr_req, irq_mask}, 0);
        run_seq(4'h5, 32'h1234_5678, 3, 4, 2, 1'b0);
        run_seq(4'hA, 32'h8000_00A5, 0, 0, 0, 1'b0);
        run_seq(4'hF, 32'h0000_0000, 5, 1, 6, 1'b1);
        run_seq(4'h0, 32'hFFFF_FFFF, 2, 7, 1, 1'b1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
        chk(!busy && !done, "R11 idle at end", {busy, done}, 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule